// File: doc/BRIEF.md
# Self-Reversing Cascaded Up/Down Counter

This block is a fully synchronous counter built from a chain of identical digit stages. It starts at zero and counts up to full scale. It then turns around by itself, counts back down to zero, turns around again, and repeats this cycle without end. Every stage keeps its own terminal flags for the top and the bottom of its digit range. A stage passes a carry or a borrow to the next stage only when every stage below it sits at its terminal value for the current direction.

A single direction flag decides whether an enabled clock moves the whole count up or down. The flag changes on the same edge on which the count reaches an endpoint. That decision uses the terminal flags of all stages combined, never the flag of the top stage alone. As a result, each endpoint lasts exactly one count period and no value next to a turnaround is repeated.

A parameter picks the digit kind: decimal (0 to 9 per stage) or binary (0 to 2^W-1 per stage). The block is a plain control-style counter with no stream interface. It has a count-enable input, and the count, the direction and the two endpoint flags are plain outputs.

Top module: `pingpong_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every digit to 0 and sets the direction to up (dir_up = 1); at_zero is then 1 and at_max is 0.
- R2: While cnt_en is low, count and dir_up keep their values across clock edges.
- R3: With dir_up = 1 and cnt_en high, each edge raises the count by one. In decimal mode a digit that passes 9 returns to 0 and carries into the next digit, so for example 0009 goes to 0010 and 0099 goes to 0100.
- R4: With dir_up = 0 and cnt_en high, each edge lowers the count by one. A digit that borrows below 0 becomes the digit maximum, so for example 1000 goes to 0999.
- R5: On the edge where the count becomes full scale (all digits at the digit maximum, 9999 with the defaults), dir_up becomes 0 on that same edge. The next enabled step gives full scale minus one, so full scale is held for only one count period.
- R6: On the edge where the count becomes zero, dir_up becomes 1 on that same edge. The next enabled step gives 1, so zero is held for only one count period.
- R7: at_max is 1 exactly while the count equals full scale, and at_zero is 1 exactly while the count equals zero.
- R8: Digit i sits in count[4i+3:4i] (least significant digit at bits 3:0). No digit ever holds a value above the digit maximum.
- R9: With the binary digit mode, each digit runs from 0 to 2^DIGIT_W-1 and full scale is all ones (255 for two 4-bit digits). The same turnaround rules apply in this mode.
- R10: dir_up changes only on edges where the count arrives at zero or at full scale. A top digit reaching its own maximum, as at 0900 on the way up, does not reverse the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; one step per edge while high |
| count | output | NUM_DIGITS*DIGIT_W | Count word, least significant digit in the low bits |
| dir_up | output | 1 | 1 while counting up, 0 while counting down |
| at_max | output | 1 | High while the count is full scale |
| at_zero | output | 1 | High while the count is zero |

## Verification
The assertions check a set of rules on every cycle after reset:
- the hold behaviour when the enable is low;
- that no digit goes out of its range;
- that the direction agrees with each endpoint;
- that the direction changes only at an endpoint;
- that an enabled step always leaves an endpoint after one period.

Some behaviour only the bench's scenarios can show. These are the exact step values across decimal carries and borrows, and the sequence max-1, max, max-1 and 1, 0, 1 through complete up and down sweeps. The bench compares them against an integer reference model, in both digit modes.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Largest value a single digit may hold for the chosen digit kind.
  function automatic int unsigned digit_top(input bit decimal, input int unsigned width);
    return decimal ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/pp_digit_stage.sv
module pp_digit_stage #(
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned DIGIT_MAX = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic               go_up,
  output logic [DIGIT_W-1:0] q,
  output logic               tc_up,
  output logic               tc_dn,
  output logic               nxt_tc_up,
  output logic               nxt_tc_dn
);

  localparam logic [DIGIT_W-1:0] TOP  = DIGIT_W'(DIGIT_MAX);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);
  localparam logic [DIGIT_W-1:0] ZERO = '0;

  logic [DIGIT_W-1:0] q_r;
  logic [DIGIT_W-1:0] q_d;

  assign tc_up = (q_r == TOP);
  assign tc_dn = (q_r == ZERO);

  always_comb begin
    q_d = q_r;
    if (advance) begin
      if (go_up) q_d = tc_up ? ZERO : (q_r + ONE);
      else       q_d = tc_dn ? TOP  : (q_r - ONE);
    end
  end

  assign nxt_tc_up = (q_d == TOP);
  assign nxt_tc_dn = (q_d == ZERO);

  always_ff @(posedge clk) begin
    if (rst) q_r <= ZERO;
    else     q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/pp_endpoint_and.sv
module pp_endpoint_and #(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS-1:0] up_flags,
  input  logic [NUM_DIGITS-1:0] dn_flags,
  output logic                  all_full,
  output logic                  all_zero
);

  assign all_full = &up_flags;
  assign all_zero = &dn_flags;

endmodule

// File: rtl/pp_dir_ctrl.sv
module pp_dir_ctrl
  import pingpong_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic next_full,
  input  logic next_zero,
  output dir_e dir
);

  dir_e dir_r;

  always_ff @(posedge clk) begin
    if (rst)                    dir_r <= DIR_UP;
    else if (step && next_zero) dir_r <= DIR_UP;
    else if (step && next_full) dir_r <= DIR_DOWN;
  end

  assign dir = dir_r;

endmodule

// File: rtl/pingpong_counter.sv
module pingpong_counter
  import pingpong_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIGIT_W    = 4,
  parameter bit          DECIMAL    = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cnt_en,
  output logic [NUM_DIGITS*DIGIT_W-1:0] count,
  output logic                          dir_up,
  output logic                          at_max,
  output logic                          at_zero
);

  localparam int unsigned DIGIT_MAX = digit_top(DECIMAL, DIGIT_W);

  logic [NUM_DIGITS:0]   adv;
  logic [NUM_DIGITS-1:0] tc_up;
  logic [NUM_DIGITS-1:0] tc_dn;
  logic [NUM_DIGITS-1:0] nxt_up;
  logic [NUM_DIGITS-1:0] nxt_dn;
  logic                  next_full;
  logic                  next_zero;
  dir_e                  dir;

  assign adv[0] = cnt_en;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
    pp_digit_stage #(
      .DIGIT_W  (DIGIT_W),
      .DIGIT_MAX(DIGIT_MAX)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .advance  (adv[k]),
      .go_up    (dir == DIR_UP),
      .q        (count[k*DIGIT_W +: DIGIT_W]),
      .tc_up    (tc_up[k]),
      .tc_dn    (tc_dn[k]),
      .nxt_tc_up(nxt_up[k]),
      .nxt_tc_dn(nxt_dn[k])
    );
    assign adv[k+1] = adv[k] & ((dir == DIR_UP) ? tc_up[k] : tc_dn[k]);
  end

  pp_endpoint_and #(.NUM_DIGITS(NUM_DIGITS)) u_now (
    .up_flags(tc_up),
    .dn_flags(tc_dn),
    .all_full(at_max),
    .all_zero(at_zero)
  );

  pp_endpoint_and #(.NUM_DIGITS(NUM_DIGITS)) u_next (
    .up_flags(nxt_up),
    .dn_flags(nxt_dn),
    .all_full(next_full),
    .all_zero(next_zero)
  );

  pp_dir_ctrl u_dir (
    .clk      (clk),
    .rst      (rst),
    .step     (cnt_en),
    .next_full(next_full),
    .next_zero(next_zero),
    .dir      (dir)
  );

  assign dir_up = (dir == DIR_UP);

endmodule

// File: rtl/pingpong_counter_chk.sv
module pingpong_counter_chk #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIGIT_W    = 4,
  parameter bit          DECIMAL    = 1'b1
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cnt_en,
  input logic [NUM_DIGITS*DIGIT_W-1:0] count,
  input logic                          dir_up,
  input logic                          at_max,
  input logic                          at_zero
);

  localparam int unsigned DMAX = DECIMAL ? 9 : ((1 << DIGIT_W) - 1);
  localparam logic [DIGIT_W-1:0] DMAX_V = DIGIT_W'(DMAX);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(count) && $stable(dir_up))); // R2

  AST_MAX_POINTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    at_max |-> !dir_up); // R5

  AST_MAX_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (at_max && cnt_en) |=> !at_max); // R5

  AST_ZERO_POINTS_UP: assert property (@(posedge clk) disable iff (rst)
    at_zero |-> dir_up); // R6

  AST_ZERO_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (at_zero && cnt_en) |=> !at_zero); // R6

  AST_ENDPOINTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(at_max && at_zero)); // R7

  AST_FLIP_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    (dir_up != $past(dir_up)) |-> (at_max || at_zero)); // R10

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_range
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
      count[g*DIGIT_W +: DIGIT_W] <= DMAX_V); // R8
  end

endmodule

bind pingpong_counter pingpong_counter_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .DIGIT_W   (DIGIT_W),
  .DECIMAL   (DECIMAL)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt_en (cnt_en),
  .count  (count),
  .dir_up (dir_up),
  .at_max (at_max),
  .at_zero(at_zero)
);

// File: tb/sim_pingpong_counter.sv
module sim_pingpong_counter;

  localparam int CLK_PERIOD = 10;
  localparam int DEC_MAX    = 9999;
  localparam int BIN_MAX    = 255;

  // {cnt_en, expected decimal count after the edge}, starting from reset
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'h0001}, {1'b1, 16'h0002}, {1'b0, 16'h0002}, {1'b1, 16'h0003},
    {1'b0, 16'h0003}, {1'b0, 16'h0003}, {1'b1, 16'h0004}, {1'b1, 16'h0005}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] cnt0;
  logic [7:0]  cnt1;
  logic        up0, mx0, zr0, up1, mx1, zr1;

  int checks = 0;
  int errors = 0;
  int m0 = 0, m1 = 0;
  bit d0 = 1'b1, d1 = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(en), .count(cnt0),
    .dir_up(up0), .at_max(mx0), .at_zero(zr0)
  );

  pingpong_counter #(.NUM_DIGITS(2), .DIGIT_W(4), .DECIMAL(1'b0)) u1 (
    .clk(clk), .rst(rst), .cnt_en(en), .count(cnt1),
    .dir_up(up1), .at_max(mx1), .at_zero(zr1)
  );

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (d0) begin m0++; if (m0 == DEC_MAX) d0 = 1'b0; end
    else    begin m0--; if (m0 == 0) d0 = 1'b1; end
    if (d1) begin m1++; if (m1 == BIN_MAX) d1 = 1'b0; end
    else    begin m1--; if (m1 == 0) d1 = 1'b1; end
  endtask

  task automatic tick(input logic e);
    @(negedge clk);
    en = e;
    @(posedge clk);
    #1;
    if (e) model_step();
  endtask

  task automatic compare_all(input string tag);
    check({tag, " count"}, int'(cnt0), int'(to_bcd(m0)));
    check("R10 direction", int'(up0), int'(d0));
    check("R7 at_max", int'(mx0), int'(m0 == DEC_MAX));
    check("R7 at_zero", int'(zr0), int'(m0 == 0));
    check("R9 binary count", int'(cnt1), m1);
    check("R9 binary direction", int'(up1), int'(d1));
    check("R9 binary at_max", int'(mx1), int'(m1 == BIN_MAX));
  endtask

  task automatic run_until(input int target, input string tag);
    for (int n = 0; n < 30000 && m0 != target; n++) begin
      tick(1'b1);
      compare_all(tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m0 = 0; m1 = 0; d0 = 1'b1; d1 = 1'b1;
    check("R1 reset count", int'(cnt0), 0);
    check("R1 reset dir", int'(up0), 1);
    check("R1 reset at_zero", int'(zr0), 1);
    check("R1 reset at_max", int'(mx0), 0);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // Vector table: R3 stepping with R2 idle cycles mixed in
    for (int i = 0; i < 8; i++) begin
      tick(VEC[i][16]);
      check(VEC[i][16] ? "R3 table step" : "R2 table hold", int'(cnt0), int'(VEC[i][15:0]));
    end

    // Decimal carries: R3
    run_until(9, "R3");
    tick(1'b1); check("R3 carry 0009->0010", int'(cnt0), 16'h0010);
    run_until(99, "R3");
    tick(1'b1); check("R3 carry 0099->0100", int'(cnt0), 16'h0100);

    // Top digit at its own max must not reverse: R10
    run_until(900, "R10");
    check("R10 no flip at 0900", int'(up0), 1);
    tick(1'b1); check("R10 0901 after 0900", int'(cnt0), 16'h0901);

    // Full-scale turnaround: R5
    run_until(DEC_MAX, "R5");
    check("R5 full count", int'(cnt0), 16'h9999);
    check("R5 dir down at full", int'(up0), 0);
    check("R5 at_max", int'(mx0), 1);
    tick(1'b0); check("R2 hold at full", int'(cnt0), 16'h9999);
    check("R2 dir hold", int'(up0), 0);
    tick(1'b1); check("R5 step after full", int'(cnt0), 16'h9998);

    // Borrows downward: R4
    run_until(1000, "R4");
    tick(1'b1); check("R4 borrow 1000->0999", int'(cnt0), 16'h0999);

    // Zero turnaround: R6
    run_until(0, "R6");
    check("R6 zero count", int'(cnt0), 0);
    check("R6 dir up at zero", int'(up0), 1);
    tick(1'b1); check("R6 step after zero", int'(cnt0), 16'h0001);
    compare_all("R6");

    // Reset in the middle of a run: R1
    run_until(37, "R3");
    do_reset();
    tick(1'b1); check("R1 first step after reset", int'(cnt0), 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule